// File: doc/BRIEF.md
# Delayed Branch Redirect Unit

This block sits between the issue stage and instruction fetch. In every clock cycle it looks at three branch slots. Each slot carries an opcode, a guard bit, a condition value and a target address. The block decides which slots resolve as taken and picks the target that wins.

The winning target does not reach fetch at once. It travels through a fixed chain of pipeline registers, three by default, and then appears as a one-cycle redirect strobe with its target address. When more than one slot is taken in the same cycle, the block flags an error and still picks one slot, so the result stays deterministic. A stall input freezes the whole chain, and slot inputs offered while stalled are ignored.

Opcode encoding per 2-bit slot field (slot n occupies bits 2n+1..2n of `slotOp`; slot n's target occupies bits 32n+31..32n of `slotTarget`):

| Code | Meaning |
|------|---------|
| 0 | not a branch |
| 1 | unconditional |
| 2 | taken when the condition bit is 1 |
| 3 | taken when the condition bit is 0 |

Top module: `branch_redirect`

## Requirements
- R1: While `rstN` is low, `redirectValid` and `multiTakenErr` are 0.
- R2: A slot whose opcode is 0 is never taken, whatever its guard and condition bits are.
- R3: A slot whose guard bit is 0 is never taken, whatever its opcode and condition bit are.
- R4: A slot with opcode 1 and guard 1 is taken for either condition value.
- R5: With guard 1, opcode 2 is taken exactly when the condition is 1, and opcode 3 is taken exactly when the condition is 0.
- R6: A taken branch captured at rising edge N, with no stall, raises `redirectValid` with its target between edge N+2 and edge N+3. The strobe is low in the two cycles before that.
- R7: Each capture cycle that has a taken slot yields its own one-cycle redirect. Branches captured on back-to-back edges give redirects on back-to-back cycles, in the same order.
- R8: When two or more slots are taken at edge N, the target of the lowest-numbered taken slot is used, and `multiTakenErr` is 1 between edge N and edge N+1.
- R9: When at most one slot is taken at an unstalled edge, `multiTakenErr` is 0 after that edge.
- R10: While `stall` is 1 at an edge, every pipeline stage, `redirectValid`, `redirectTarget` and `multiTakenErr` hold their values. Slot inputs at that edge are ignored, and the pending redirect emerges once the missing stall-free edges have occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes the redirect pipeline and ignores slot inputs |
| slotOp | input | 6 | Three 2-bit opcodes, slot 0 in the low bits |
| slotGuard | input | 3 | Guard bit per slot |
| slotCond | input | 3 | Condition value per slot |
| slotTarget | input | 96 | Three 32-bit targets, slot 0 in the low bits |
| redirectValid | output | 1 | One-cycle fetch redirect strobe |
| redirectTarget | output | 32 | Redirect address, meaningful while redirectValid is 1 |
| multiTakenErr | output | 1 | More than one slot was taken at the last capture |

## Verification
On every cycle, the assertions check that a stall freezes the outputs, and that a cleared guard or an all-zero opcode set never raises the error flag. They also check that an unconditional slot-0 branch followed by two stall-free edges always produces a redirect. The bench's scenarios are needed to show the values of the redirect address, the lowest-slot priority under conflicts, and the condition polarity of opcodes 2 and 3. They also cover ordering of back-to-back redirects and the fact that slot inputs offered during a stall are dropped.

// File: rtl/branch_redirect_pkg.sv
package branch_redirect_pkg;
  parameter int SLOT_COUNT = 3;
  parameter int OP_W       = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE     = 2'd0,
    OP_ALWAYS   = 2'd1,
    OP_IF_SET   = 2'd2,
    OP_IF_CLEAR = 2'd3
  } brOp_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic                  advance;   // pipeline may shift
    logic                  loadValid; // some slot is taken
    logic                  multiHit;  // more than one slot taken
    logic [SLOT_COUNT-1:0] pick;      // one-hot winning slot
  } ctrlStrobe_t;
endpackage

// File: rtl/branch_redirect_ctrl.sv
module branch_redirect_ctrl
  import branch_redirect_pkg::*;
(
  input  logic                       stall,
  input  logic [SLOT_COUNT*OP_W-1:0] slotOp,
  input  logic [SLOT_COUNT-1:0]      slotGuard,
  input  logic [SLOT_COUNT-1:0]      slotCond,
  output ctrlStrobe_t                strobe
);
  localparam logic [SLOT_COUNT-1:0] ONE = {{(SLOT_COUNT-1){1'b0}}, 1'b1};

  logic [SLOT_COUNT-1:0] hit;

  // Per-slot taken decision
  for (genvar gi = 0; gi < SLOT_COUNT; gi++) begin : g_slot
    brOp_e opCode;
    assign opCode = brOp_e'(slotOp[gi*OP_W +: OP_W]);
    always_comb begin
      unique case (opCode)
        OP_ALWAYS:   hit[gi] = slotGuard[gi];
        OP_IF_SET:   hit[gi] = slotGuard[gi] &  slotCond[gi];
        OP_IF_CLEAR: hit[gi] = slotGuard[gi] & ~slotCond[gi];
        default:     hit[gi] = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.advance   = ~stall;
    strobe.loadValid = |hit;
    strobe.pick      = hit & (~hit + ONE);       // lowest set bit
    strobe.multiHit  = (hit & (hit - ONE)) != '0; // two or more set
  end
endmodule

// File: rtl/branch_redirect_dp.sv
module branch_redirect_dp
  import branch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DELAY  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [SLOT_COUNT*ADDR_W-1:0] slotTarget,
  output logic                         redirectValid,
  output logic [ADDR_W-1:0]            redirectTarget,
  output logic                         multiTakenErr
);
  localparam int LAST = DELAY - 1;

  logic              vldStg [DELAY];
  logic [ADDR_W-1:0] tgtStg [DELAY];
  logic [ADDR_W-1:0] pickedTgt;
  logic              errReg;

  // One-hot select of the winning target
  always_comb begin
    pickedTgt = '0;
    for (int s = 0; s < SLOT_COUNT; s++) begin
      if (strobe.pick[s]) pickedTgt |= slotTarget[s*ADDR_W +: ADDR_W];
    end
  end

  for (genvar st = 0; st < DELAY; st++) begin : g_stage
    logic              vldIn;
    logic [ADDR_W-1:0] tgtIn;
    if (st == 0) begin : g_head
      assign vldIn = strobe.loadValid;
      assign tgtIn = pickedTgt;
    end else begin : g_body
      assign vldIn = vldStg[st-1];
      assign tgtIn = tgtStg[st-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldStg[st] <= 1'b0;
        tgtStg[st] <= '0;
      end else if (strobe.advance) begin
        vldStg[st] <= vldIn;
        tgtStg[st] <= tgtIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errReg <= 1'b0;
    else if (strobe.advance) errReg <= strobe.multiHit;
  end

  assign redirectValid  = vldStg[LAST];
  assign redirectTarget = tgtStg[LAST];
  assign multiTakenErr  = errReg;
endmodule

// File: rtl/branch_redirect.sv
module branch_redirect
  import branch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DELAY  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         stall,
  input  logic [SLOT_COUNT*OP_W-1:0]   slotOp,
  input  logic [SLOT_COUNT-1:0]        slotGuard,
  input  logic [SLOT_COUNT-1:0]        slotCond,
  input  logic [SLOT_COUNT*ADDR_W-1:0] slotTarget,
  output logic                         redirectValid,
  output logic [ADDR_W-1:0]            redirectTarget,
  output logic                         multiTakenErr
);
  ctrlStrobe_t strobe;

  branch_redirect_ctrl u_ctrl (
    .stall     (stall),
    .slotOp    (slotOp),
    .slotGuard (slotGuard),
    .slotCond  (slotCond),
    .strobe    (strobe)
  );

  branch_redirect_dp #(.ADDR_W(ADDR_W), .DELAY(DELAY)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .slotTarget     (slotTarget),
    .redirectValid  (redirectValid),
    .redirectTarget (redirectTarget),
    .multiTakenErr  (multiTakenErr)
  );
endmodule

// File: rtl/branch_redirect_chk.sv
module branch_redirect_chk
  import branch_redirect_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         stall,
  input logic [SLOT_COUNT*OP_W-1:0]   slotOp,
  input logic [SLOT_COUNT-1:0]        slotGuard,
  input logic [SLOT_COUNT-1:0]        slotCond,
  input logic [SLOT_COUNT*ADDR_W-1:0] slotTarget,
  input logic                         redirectValid,
  input logic [ADDR_W-1:0]            redirectTarget,
  input logic                         multiTakenErr
);
  // R10: a stalled edge changes no output
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(redirectValid) && $stable(redirectTarget) && $stable(multiTakenErr)));

  // R3: with every guard low nothing can conflict
  p_guard_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && slotGuard == '0) |=> !multiTakenErr);

  // R2: all opcodes zero means no conflict
  p_no_branch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && slotOp == '0) |=> !multiTakenErr);

  // R6: unconditional guarded slot 0 arrives after two further free edges
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && slotGuard[0] && slotOp[OP_W-1:0] == 2'd1) ##1 !stall ##1 !stall
      |=> redirectValid);
endmodule

bind branch_redirect branch_redirect_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/branch_redirect_tb.sv
module branch_redirect_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stall;
  logic [5:0]  slotOp;
  logic [2:0]  slotGuard;
  logic [2:0]  slotCond;
  logic [95:0] slotTarget;
  logic        redirectValid;
  logic [31:0] redirectTarget;
  logic        multiTakenErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_redirect u_dut (
    .clk(clk), .rstN(rstN), .stall(stall), .slotOp(slotOp),
    .slotGuard(slotGuard), .slotCond(slotCond), .slotTarget(slotTarget),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget),
    .multiTakenErr(multiTakenErr)
  );

  function automatic logic [5:0] ops(logic [1:0] s0, logic [1:0] s1, logic [1:0] s2);
    return {s2, s1, s0};
  endfunction

  function automatic logic [95:0] tgts(logic [31:0] t0, logic [31:0] t1, logic [31:0] t2);
    return {t2, t1, t0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearSlots();
    slotOp = '0; slotGuard = '0; slotCond = '0; slotTarget = '0;
  endtask

  // Issue one cycle of slots, then follow the redirect pipeline
  task automatic runOne(string tag, logic [5:0] op, logic [2:0] g, logic [2:0] c,
                        logic [95:0] t, logic expV, logic [31:0] expT, logic expE);
    @(negedge clk);
    slotOp = op; slotGuard = g; slotCond = c; slotTarget = t;
    @(negedge clk);
    clearSlots();
    chk({tag, " err"}, 32'(multiTakenErr), 32'(expE));
    chk({tag, " early+1"}, 32'(redirectValid), 0);
    @(negedge clk);
    chk({tag, " early+2"}, 32'(redirectValid), 0);
    @(negedge clk);
    chk({tag, " valid"}, 32'(redirectValid), 32'(expV));
    if (expV) chk({tag, " target"}, redirectTarget, expT);
    @(negedge clk);
    chk({tag, " pulse end"}, 32'(redirectValid), 0);
  endtask

  task automatic testReset();
    chk("R1 valid in reset", 32'(redirectValid), 0);
    chk("R1 err in reset", 32'(multiTakenErr), 0);
  endtask

  task automatic testDecode();
    runOne("R2 opcode0", ops(0, 0, 0), 3'b111, 3'b101,
           tgts(32'h100, 32'h200, 32'h300), 0, 0, 0);
    runOne("R3 guard0", ops(1, 1, 1), 3'b000, 3'b011,
           tgts(32'h110, 32'h210, 32'h310), 0, 0, 0);
    runOne("R4 uncond c0", ops(0, 1, 0), 3'b010, 3'b000,
           tgts(32'h0, 32'hA000_1000, 32'h0), 1, 32'hA000_1000, 0);
    runOne("R4 uncond c1", ops(0, 0, 1), 3'b100, 3'b100,
           tgts(32'h0, 32'h0, 32'hA000_2000), 1, 32'hA000_2000, 0);
    runOne("R5 ifset c1", ops(2, 0, 0), 3'b001, 3'b001,
           tgts(32'hB000_0010, 0, 0), 1, 32'hB000_0010, 0);
    runOne("R5 ifset c0", ops(2, 0, 0), 3'b001, 3'b000,
           tgts(32'hB000_0020, 0, 0), 0, 0, 0);
    runOne("R5 ifclear c0", ops(0, 3, 0), 3'b010, 3'b000,
           tgts(0, 32'hB000_0030, 0), 1, 32'hB000_0030, 0);
    runOne("R5 ifclear c1", ops(0, 3, 0), 3'b010, 3'b010,
           tgts(0, 32'hB000_0040, 0), 0, 0, 0);
  endtask

  task automatic testConflict();
    runOne("R8 slots1+2", ops(0, 1, 2), 3'b110, 3'b100,
           tgts(32'hC000_0000, 32'hC000_0001, 32'hC000_0002), 1, 32'hC000_0001, 1);
    runOne("R8 all three", ops(1, 2, 3), 3'b111, 3'b010,
           tgts(32'hC100_0000, 32'hC100_0001, 32'hC100_0002), 1, 32'hC100_0000, 1);
    runOne("R9 one of three", ops(1, 2, 3), 3'b111, 3'b100,
           tgts(32'hC200_0000, 32'hC200_0001, 32'hC200_0002), 1, 32'hC200_0000, 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    slotOp = ops(1, 0, 0); slotGuard = 3'b001; slotCond = 0;
    slotTarget = tgts(32'hD000_0000, 0, 0);
    @(negedge clk);
    slotOp = ops(0, 0, 2); slotGuard = 3'b100; slotCond = 3'b100;
    slotTarget = tgts(0, 0, 32'hD000_0004);
    @(negedge clk);
    clearSlots();
    @(negedge clk);
    chk("R7 first valid", 32'(redirectValid), 1);
    chk("R7 first target", redirectTarget, 32'hD000_0000);
    @(negedge clk);
    chk("R7 second valid", 32'(redirectValid), 1);
    chk("R7 second target", redirectTarget, 32'hD000_0004);
    @(negedge clk);
    chk("R7 drained", 32'(redirectValid), 0);
  endtask

  task automatic testStallMidway();
    @(negedge clk);
    slotOp = ops(0, 1, 0); slotGuard = 3'b010; slotCond = 0;
    slotTarget = tgts(0, 32'hE000_0000, 0);
    @(negedge clk);
    stall = 1'b1;                       // stalled edges see a conflicting pair
    slotOp = ops(1, 1, 0); slotGuard = 3'b011;
    slotTarget = tgts(32'hEEEE_0000, 32'hEEEE_0001, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held valid", 32'(redirectValid), 0);
      chk("R10 held err", 32'(multiTakenErr), 0);
    end
    stall = 1'b0;
    clearSlots();
    @(negedge clk);
    chk("R10 still pending", 32'(redirectValid), 0);
    @(negedge clk);
    chk("R10 late valid", 32'(redirectValid), 1);
    chk("R10 late target", redirectTarget, 32'hE000_0000);
    @(negedge clk);
    chk("R10 stalled input dropped", 32'(redirectValid), 0);
    @(negedge clk);
    chk("R10 nothing follows", 32'(redirectValid), 0);
  endtask

  task automatic testStallOnOutput();
    @(negedge clk);
    slotOp = ops(0, 0, 1); slotGuard = 3'b100; slotCond = 0;
    slotTarget = tgts(0, 0, 32'hF000_0008);
    @(negedge clk);
    clearSlots();
    @(negedge clk);
    @(negedge clk);
    chk("R6 on time", 32'(redirectValid), 1);
    stall = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R10 output frozen", 32'(redirectValid), 1);
      chk("R10 target frozen", redirectTarget, 32'hF000_0008);
    end
    stall = 1'b0;
    @(negedge clk);
    chk("R10 released", 32'(redirectValid), 0);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; stall = 1'b0;
    clearSlots();
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testDecode();
    testConflict();
    testBackToBack();
    testStallMidway();
    testStallOnOutput();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end
endmodule